// File: doc/BRIEF.md
# Integer Multiply-Divide Unit

This block is a 32-bit integer arithmetic engine that a processor pipeline hands one operation at a time. It covers nine operations: the low word of a product, the high word of an unsigned or signed 64-bit product, unsigned and signed multiplies of the low halves, and unsigned and signed quotient and remainder. The caller presents an operation code and two operands with a one-cycle `start` request. The unit then raises `busy`, and later pulses `done` with either a result or a divide-by-zero flag.

Multiplies finish in a single working cycle. Division uses a restoring divider on operand magnitudes that produces one quotient bit per cycle, and the signs are corrected when the result is captured. The controller has four states. IDLE waits for a request. MUL registers the product. DIV waits on the iterative divider. DONE presents the outcome for one cycle.

The transitions are:
- IDLE to MUL on an accepted multiply or unused code.
- IDLE to DIV on an accepted divide with a nonzero divisor.
- IDLE to DONE on an accepted divide by zero.
- MUL to DONE after one cycle.
- DIV to DONE when the divider reports completion.
- DONE to IDLE after one cycle.

Top module: `imd_unit`

## Requirements
- R1: Operation code 0 returns bits 31:0 of the product of the two operands.
- R2: Code 1 returns bits 63:32 of the product of the zero-extended operands, and code 2 returns bits 63:32 of the product of the sign-extended operands.
- R3: Code 3 multiplies the zero-extended low 16 bits of each operand, and code 4 multiplies the sign-extended low 16 bits; both return the 32-bit product.
- R4: Code 5 returns the unsigned quotient of operand A by operand B, and code 7 returns the unsigned remainder. The remainder is always below the divisor.
- R5: Code 6 returns the signed quotient, truncated toward zero. Code 8 returns the signed remainder, which carries the sign of the dividend.
- R6: A signed quotient of 0x80000000 by 0xFFFFFFFF yields 0x80000000, and the matching signed remainder yields 0.
- R7: Codes 5 to 8 with a zero divisor end with `dz_flag` high during the `done` cycle. The `result` output keeps its previous value.
- R8: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle, and `done` lasts exactly one cycle.
- R9: Counted in rising edges after the accepting edge, `done` appears after 1 edge for a multiply, after 33 edges for a divide with a nonzero divisor, and at once (0 edges) for a divide by zero.
- R10: A `start` that is asserted while `busy` is high is ignored. The operation in flight completes with its original result.
- R11: After reset, `busy`, `done` and `dz_flag` are low and `result` is zero.
- R12: Codes 9 to 15 complete like a multiply and return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation (taken when busy is low) |
| op | input | 4 | Operation code, 0 to 8 (see R1 to R5, R12) |
| opa | input | 32 | Operand A (multiplicand or dividend) |
| opb | input | 32 | Operand B (multiplier or divisor) |
| busy | output | 1 | Unit is working or presenting a result |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Result of the last completed operation |
| dz_flag | output | 1 | Divide-by-zero indication, valid with done |

## Verification
A wrong divider state, such as a miscounted step or a bad restore decision, appears at the `done` pulse of the next division. It shows either as a wrong quotient or remainder, or as a completion that does not land exactly 33 edges after acceptance. A stuck controller shows up as a missing `done` or as `busy` staying high, and a random mix of operations exposes this within one request. A misapplied sign correction is visible only on signed operations with negative operands, so random signed divisions with both operand signs, together with the overflow corner, reveal it on the first such case.

// File: rtl/imd_pkg.sv
package imd_pkg;

    typedef enum logic [3:0] {
        OP_MULL   = 4'd0,
        OP_MULUH  = 4'd1,
        OP_MULSH  = 4'd2,
        OP_MUL16U = 4'd3,
        OP_MUL16S = 4'd4,
        OP_QUOU   = 4'd5,
        OP_QUOS   = 4'd6,
        OP_REMU   = 4'd7,
        OP_REMS   = 4'd8
    } imd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2,
        ST_DONE = 2'd3
    } imd_state_e;

    function automatic logic op_is_div(input logic [3:0] code);
        return (code >= 4'd5) && (code <= 4'd8);
    endfunction

    function automatic logic op_is_signed_div(input logic [3:0] code);
        return (code == 4'd6) || (code == 4'd8);
    endfunction

    function automatic logic op_is_rem(input logic [3:0] code);
        return (code == 4'd7) || (code == 4'd8);
    endfunction

endpackage

// File: rtl/imd_mul.sv
module imd_mul
    import imd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam int HW = W / 2;
    localparam int XW = W + 1;
    localparam int PW = 2 * XW;

    logic signed [XW-1:0] ax;
    logic signed [XW-1:0] bx;
    logic signed [PW-1:0] prod;

    always_comb begin
        ax = '0;
        bx = '0;
        unique case (op)
            OP_MULL, OP_MULUH: begin
                ax = {1'b0, a};
                bx = {1'b0, b};
            end
            OP_MULSH: begin
                ax = {a[W-1], a};
                bx = {b[W-1], b};
            end
            OP_MUL16U: begin
                ax = {{(XW-HW){1'b0}}, a[HW-1:0]};
                bx = {{(XW-HW){1'b0}}, b[HW-1:0]};
            end
            OP_MUL16S: begin
                ax = {{(XW-HW){a[HW-1]}}, a[HW-1:0]};
                bx = {{(XW-HW){b[HW-1]}}, b[HW-1:0]};
            end
            default: begin
                ax = '0;
                bx = '0;
            end
        endcase
    end

    assign prod = ax * bx;

    always_comb begin
        unique case (op)
            OP_MULL, OP_MUL16U, OP_MUL16S: y = prod[W-1:0];
            OP_MULUH, OP_MULSH:            y = prod[2*W-1:W];
            default:                       y = '0;
        endcase
    end

endmodule

// File: rtl/imd_div.sv
module imd_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    logic [CW-1:0] cnt;
    logic [W-1:0]  part;
    logic [W-1:0]  qsh;
    logic [W-1:0]  dvs_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    assign shifted = {part, qsh[W-1]};
    assign trial   = shifted - {1'b0, dvs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= LAST;
            part  <= '0;
            qsh   <= '0;
            dvs_q <= '0;
        end else if (load) begin
            cnt   <= '0;
            part  <= '0;
            qsh   <= dvd;
            dvs_q <= dvs;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
            if (!trial[W]) begin
                part <= trial[W-1:0];
                qsh  <= {qsh[W-2:0], 1'b1};
            end else begin
                part <= shifted[W-1:0];
                qsh  <= {qsh[W-2:0], 1'b0};
            end
        end
    end

    assign fin = (cnt == LAST);
    assign quo = qsh;
    assign rem = part;

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    p_rem_below_dvs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && dvs_q != '0) |-> (part < dvs_q));

    p_step_advances_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fin && !load) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/imd_unit.sv
module imd_unit
    import imd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [3:0]   op,
    input  logic [31:0]  opa,
    input  logic [31:0]  opb,
    output logic         busy,
    output logic         done,
    output logic [31:0]  result,
    output logic         dz_flag
);
    imd_state_e state, state_nx;

    logic [3:0]   op_q;
    logic [W-1:0] a_q, b_q;
    logic         quo_neg_q, rem_neg_q;
    logic [W-1:0] result_q;
    logic         dz_q;

    logic         accept;
    logic         div_req;
    logic         dz_req;
    logic         div_load;
    logic         neg_a, neg_b;
    logic [W-1:0] mag_a, mag_b;
    logic [W-1:0] mul_y;
    logic [W-1:0] dq, dr, dq_fix, dr_fix;
    logic         div_fin;

    assign accept   = start && (state == ST_IDLE);
    assign div_req  = op_is_div(op);
    assign dz_req   = div_req && (opb == '0);
    assign div_load = accept && div_req && !dz_req;

    assign neg_a = op_is_signed_div(op) && opa[W-1];
    assign neg_b = op_is_signed_div(op) && opb[W-1];
    assign mag_a = neg_a ? (~opa + 1'b1) : opa;
    assign mag_b = neg_b ? (~opb + 1'b1) : opb;

    imd_mul #(.W(W)) u_mul (
        .op (op_q),
        .a  (a_q),
        .b  (b_q),
        .y  (mul_y)
    );

    imd_div #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_load),
        .dvd   (mag_a),
        .dvs   (mag_b),
        .quo   (dq),
        .rem   (dr),
        .fin   (div_fin)
    );

    assign dq_fix = quo_neg_q ? (~dq + 1'b1) : dq;
    assign dr_fix = rem_neg_q ? (~dr + 1'b1) : dr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (!div_req)    state_nx = ST_MUL;
                    else if (dz_req) state_nx = ST_DONE;
                    else             state_nx = ST_DIV;
                end
            end
            ST_MUL:  state_nx = ST_DONE;
            ST_DIV:  if (div_fin) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // operand capture and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            a_q       <= '0;
            b_q       <= '0;
            quo_neg_q <= 1'b0;
            rem_neg_q <= 1'b0;
            result_q  <= '0;
            dz_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_q      <= op;
                        a_q       <= opa;
                        b_q       <= opb;
                        quo_neg_q <= !op_is_rem(op) && (neg_a ^ neg_b);
                        rem_neg_q <= op_is_rem(op) && neg_a;
                        dz_q      <= dz_req;
                    end
                end
                ST_MUL: result_q <= mul_y;
                ST_DIV: begin
                    if (div_fin) result_q <= op_is_rem(op_q) ? dr_fix : dq_fix;
                end
                ST_DONE: dz_q <= 1'b0;
                default: dz_q <= 1'b0;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign result  = result_q;
    assign dz_flag = dz_q;

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_dz_only_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dz_flag |-> done);

    p_dz_keeps_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dz_flag |-> $stable(result));

    p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(op_q) && $stable(a_q) && $stable(b_q));

endmodule

// File: tb/imd_unit_test.sv
`timescale 1ns/1ps
module imd_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        busy, done, dz_flag;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    imd_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .done(done),
        .result(result), .dz_flag(dz_flag)
    );

    function automatic logic [31:0] model(input logic [3:0] c,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa, sb, ua, ub, r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = longint'({32'd0, a});
        ub = longint'({32'd0, b});
        case (c)
            4'd0: r = ua * ub;
            4'd1: begin
                logic [63:0] p;
                p = {32'd0, a} * {32'd0, b};
                r = longint'(p >> 32);
            end
            4'd2: r = (sa * sb) >>> 32;
            4'd3: r = longint'({16'd0, a[15:0]}) * longint'({16'd0, b[15:0]});
            4'd4: r = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
            4'd5: r = ua / ub;
            4'd6: r = sa / sb;
            4'd7: r = ua % ub;
            4'd8: r = sa % sb;
            default: r = 0;
        endcase
        return r[31:0];
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one op; returns result, flag and edges from acceptance to done
    task automatic run(input logic [3:0] c, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] res,
                       output logic dz, output int lat);
        @(negedge clk);
        start = 1'b1; op = c; opa = a; opb = b;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) break;
            lat++;
        end
        res = result;
        dz = dz_flag;
        if (!done) check(1'b0, "R8 done missing", 32'd0, 32'd1);
        @(negedge clk);
    endtask

    task automatic op_check(input logic [3:0] c, input logic [31:0] a,
                            input logic [31:0] b, input string tag);
        logic [31:0] res, exp;
        logic dz;
        int lat;
        run(c, a, b, res, dz, lat);
        if (c >= 4'd5 && c <= 4'd8 && b == 32'd0) begin
            check(dz == 1'b1, {tag, " R7 flag"}, {31'd0, dz}, 32'd1);
        end else begin
            exp = model(c, a, b);
            check(res == exp && !dz, tag, res, exp);
        end
    endtask

    initial begin
        #(8 * 190000);
        check(1'b0, "watchdog expired", 32'd0, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] res, keep;
        logic dz;
        int lat;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !done && !dz_flag && result == 0, "R11 reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 directed
        op_check(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 mull");
        op_check(4'd0, 32'h1234_5678, 32'h9ABC_DEF0, "R1 mull");
        op_check(4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 muluh");
        op_check(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mulsh");
        op_check(4'd2, 32'h8000_0000, 32'h7FFF_FFFF, "R2 mulsh");
        op_check(4'd3, 32'hABCD_FFFF, 32'h1234_FFFF, "R3 mul16u");
        op_check(4'd4, 32'hABCD_FFFF, 32'h1234_8000, "R3 mul16s");
        // R4 R5 directed
        op_check(4'd5, 32'hFFFF_FFFF, 32'd7, "R4 quou");
        op_check(4'd7, 32'hFFFF_FFFF, 32'd7, "R4 remu");
        op_check(4'd5, 32'd3, 32'hFFFF_FFFF, "R4 quou small");
        op_check(4'd6, 32'hFFFF_FFF9, 32'd2, "R5 quos neg");
        op_check(4'd8, 32'hFFFF_FFF9, 32'd2, "R5 rems neg");
        op_check(4'd8, 32'd7, 32'hFFFF_FFFE, "R5 rems posdvd");
        op_check(4'd6, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5 quos both neg");
        // R6 overflow
        run(4'd6, 32'h8000_0000, 32'hFFFF_FFFF, res, dz, lat);
        check(res == 32'h8000_0000, "R6 quos overflow", res, 32'h8000_0000);
        run(4'd8, 32'h8000_0000, 32'hFFFF_FFFF, res, dz, lat);
        check(res == 32'd0, "R6 rems overflow", res, 32'd0);
        // R12 unused code
        run(4'd11, 32'h55, 32'h66, res, dz, lat);
        check(res == 32'd0 && lat == 1, "R12 unused", res, 32'd0);
        // R9 latencies
        run(4'd0, 32'd9, 32'd9, res, dz, lat);
        check(lat == 1, "R9 mul latency", lat, 32'd1);
        keep = res;
        // R7 zero divisor for every divide code
        for (int c = 5; c <= 8; c++) begin
            run(4'(c), 32'h1234, 32'd0, res, dz, lat);
            check(dz == 1'b1, "R7 dz flag", {31'd0, dz}, 32'd1);
            check(res == keep, "R7 result kept", res, keep);
            check(lat == 0, "R9 dz latency", lat, 32'd0);
        end
        run(4'd5, 32'd100, 32'd7, res, dz, lat);
        check(lat == 33, "R9 div latency", lat, 32'd33);
        check(dz == 1'b0, "R7 no flag", {31'd0, dz}, 32'd0);
        // R10 start while busy
        @(negedge clk);
        start = 1'b1; op = 4'd5; opa = 32'd1000; opb = 32'd10;
        @(posedge clk);
        #1 start = 1'b0;
        repeat (5) @(negedge clk);
        check(busy == 1'b1, "R8 busy during div", {31'd0, busy}, 32'd1);
        start = 1'b1; op = 4'd0; opa = 32'd3; opb = 32'd3;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        check(result == 32'd100, "R10 intrusion ignored", result, 32'd100);
        @(negedge clk);
        check(!busy && !done, "R8 idle after done", {30'd0, busy, done}, 32'd0);
        // random mix
        for (int k = 0; k < 200; k++) begin
            logic [3:0] c;
            logic [31:0] a, b;
            c = 4'($urandom_range(0, 8));
            a = $urandom();
            b = $urandom();
            if ((k % 4) == 1) b = b >> $urandom_range(0, 31);
            if ((k % 8) == 3) a = -a;
            if (k == 50) b = 32'd0;
            op_check(c, a, b, "R1-mix random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule